// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the bus-facing control front end of a small on-chip flash store. The array is modelled as a bank of byte registers. A CPU reaches it through a simple request bus that handles byte and 16-bit word accesses, either to the array or to a 4-bit control register. Software arms a programming latch and then writes one byte or one aligned word to the array. That write is captured and not stored. Software then sets the go bit. A fixed-length pulse runs, and at its end the captured value is ANDed into the array. When the erase bit is set, the whole array returns to all ones instead.

The go bit is interlocked. It can only be set once the arm bit is set and a capture has occurred. While go is set, the other control bits are frozen and array reads return zero. The boot-lock bit shields the top `BOOT_BYTES` locations from erase.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, the control register reads 0, `busy_o` and `pulse_o` are 0, and every array byte reads 0xFF.
- R2: While arm (control bit 0) is 0, array writes leave the array unchanged.
- R3: A control write sets go (bit 2) only if arm is already 1 and a capture has happened since arm was set. Otherwise go reads 0 after the write.
- R4: While go is 1, a control write changes only go. Arm, erase (bit 1) and boot-lock (bit 3) keep their values.
- R5: With arm set, the first array write that is a byte write or an aligned word write captures its address, size and 16-bit data. Later array writes are ignored until arm is cleared.
- R6: An array read returns 0 when go=1. With go=0, arm=1 and erase=0 it returns the captured 16-bit data, or 0 if nothing has been captured. In all other cases it returns the addressed location: byte reads give {8'h00, mem[a]}, and word reads give {mem[a+1], mem[a]}.
- R7: A single control write that sets go and clears arm starts no pulse and leaves the array unchanged.
- R8: Programming ANDs the captured data into the array. A byte capture updates mem[a] with data[7:0]. An aligned word capture also updates mem[a+1] with data[15:8]. A misaligned word write is never captured.
- R9: Erase sets every byte to 0xFF, except the top `BOOT_BYTES` locations when boot-lock is 1.
- R10: When go rises with arm kept at 1, `pulse_o` is high for exactly `PULSE_CYC` cycles, and then the array update happens. `busy_o` follows go until software clears it. Clearing go during the pulse aborts it with no array change.
- R11: A byte read or an aligned word read of the array acknowledges in its first cycle. A misaligned word read acknowledges in its second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| ctl_sel_i | input | 1 | 1 = control register, 0 = array |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| addr_i | input | AW | Byte address into the array |
| wdata_i | input | 16 | Write data; control bits in [3:0] |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| ack_o | output | 1 | Access completes this cycle |
| busy_o | output | 1 | Go bit is set |
| pulse_o | output | 1 | Program/erase pulse is running |

## Verification
Most internal faults show on the ports within a cycle or two. A wrong freeze or gating decision shows in the next read of the control register. A latch that takes a second write changes the redirected read data right away. A pulse counter that is off by one changes the count of cycles during which `pulse_o` is high. A wrong AND mask or a wrong erase range stays hidden until go and arm are cleared and the array is read back. For that reason every program and erase is followed by a normal read and compared with a reference model held in the bench.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int unsigned CTL_W = 4;
  typedef struct packed {
    logic boot;   // bit 3
    logic go;     // bit 2
    logic erase;  // bit 1
    logic arm;    // bit 0
  } ctl_t;
  typedef enum logic [1:0] {RD_ARRAY, RD_LATCH, RD_BLOCK} rd_src_e;
endpackage

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_pe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  ctl_t wval_i,
  input  logic lat_valid_i,
  output ctl_t ctl_o,
  output logic start_o
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d   = ctl_q;
    start_o = 1'b0;
    if (wr_i) begin
      if (ctl_q.go) begin
        ctl_d.go = wval_i.go;  // others frozen
      end else begin
        ctl_d.arm   = wval_i.arm;
        ctl_d.erase = wval_i.erase;
        ctl_d.boot  = wval_i.boot;
        ctl_d.go    = wval_i.go && ctl_q.arm && lat_valid_i;
        // arm dropped on the same write: go sticks but nothing runs
        start_o     = ctl_d.go && wval_i.arm;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/flash_pgm_latch.sv
module flash_pgm_latch #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          cap_i,
  input  logic          b8_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic          b8_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          valid_q, b8_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          legal;

  assign legal = b8_i || !addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      b8_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!arm_i) begin
      valid_q <= 1'b0;
      b8_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cap_i && !valid_q && legal) begin
      valid_q <= 1'b1;
      b8_q    <= b8_i;
      addr_q  <= addr_i;
      data_q  <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign b8_o    = b8_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic go_i,
  output logic active_o,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (act_q) begin
      if (!go_i || cnt_q == ONE) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign active_o = act_q && go_i;
  assign fire_o   = act_q && go_i && (cnt_q == ONE);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned BOOT_BYTES = 8,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic          erase_i,
  input  logic          boot_i,
  input  logic          lat_b8_i,
  input  logic [AW-1:0] lat_addr_i,
  input  logic [15:0]   lat_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_lo_o,
  output logic [7:0]    rd_hi_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [AW-1:0] IDX  = AW'(g);
    localparam bit            PROT = (g >= int'(DEPTH) - int'(BOOT_BYTES));
    logic hit_lo, hit_hi;

    assign hit_lo = (lat_addr_i == IDX);
    assign hit_hi = !lat_b8_i && IDX[0] && !lat_addr_i[0] &&
                    (lat_addr_i[AW-1:1] == IDX[AW-1:1]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      mem_q[g] <= 8'hFF;
      else if (erase_i && !(PROT && boot_i)) mem_q[g] <= 8'hFF;
      else if (prog_i && hit_lo)        mem_q[g] <= mem_q[g] & lat_data_i[7:0];
      else if (prog_i && hit_hi)        mem_q[g] <= mem_q[g] & lat_data_i[15:8];
    end
  end

  assign rd_lo_o = mem_q[rd_addr_i];
  assign rd_hi_o = mem_q[rd_addr_i + AW'(1)];
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned BOOT_BYTES = 8,
  parameter int unsigned PULSE_CYC  = 16,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          ctl_sel_i,
  input  logic          byte_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          ack_o,
  output logic          busy_o,
  output logic          pulse_o
);
  import flash_pe_pkg::*;

  ctl_t          ctl_q;
  logic          ctl_wr, arr_acc, arr_wr, mis_rd, mis_q;
  logic          start, fire;
  logic          lat_valid, lat_b8;
  logic [AW-1:0] lat_addr;
  logic [15:0]   lat_data;
  logic [7:0]    rd_lo, rd_hi;
  rd_src_e       rd_src;

  assign arr_acc = req_i && !ctl_sel_i;
  assign arr_wr  = arr_acc && we_i;
  assign ctl_wr  = req_i && we_i && ctl_sel_i;
  assign mis_rd  = arr_acc && !we_i && !byte_i && addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mis_q <= 1'b0;
    else         mis_q <= mis_rd && !mis_q;
  end

  assign ack_o = req_i && !(mis_rd && !mis_q);

  flash_ctl_reg u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr),
    .wval_i     (ctl_t'(wdata_i[CTL_W-1:0])),
    .lat_valid_i(lat_valid),
    .ctl_o      (ctl_q),
    .start_o    (start)
  );

  flash_pgm_latch #(.AW(AW), .DW(16)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (ctl_q.arm),
    .cap_i  (arr_wr),
    .b8_i   (byte_i),
    .addr_i (addr_i),
    .data_i (wdata_i),
    .valid_o(lat_valid),
    .b8_o   (lat_b8),
    .addr_o (lat_addr),
    .data_o (lat_data)
  );

  flash_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .go_i    (ctl_q.go),
    .active_o(pulse_o),
    .fire_o  (fire)
  );

  flash_array #(.DEPTH(DEPTH), .BOOT_BYTES(BOOT_BYTES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_i    (fire && !ctl_q.erase),
    .erase_i   (fire && ctl_q.erase),
    .boot_i    (ctl_q.boot),
    .lat_b8_i  (lat_b8),
    .lat_addr_i(lat_addr),
    .lat_data_i(lat_data),
    .rd_addr_i (addr_i),
    .rd_lo_o   (rd_lo),
    .rd_hi_o   (rd_hi)
  );

  always_comb begin
    if (ctl_q.go)                        rd_src = RD_BLOCK;
    else if (ctl_q.arm && !ctl_q.erase)  rd_src = RD_LATCH;
    else                                 rd_src = RD_ARRAY;
  end

  always_comb begin
    if (ctl_sel_i) rdata_o = {{(16-CTL_W){1'b0}}, ctl_q};
    else begin
      unique case (rd_src)
        RD_BLOCK: rdata_o = '0;
        RD_LATCH: rdata_o = lat_data;
        default:  rdata_o = byte_i ? {8'h00, rd_lo} : {rd_hi, rd_lo};
      endcase
    end
  end

  assign busy_o = ctl_q.go;
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          ctl_sel_i,
  input logic          byte_i,
  input logic [AW-1:0] addr_i,
  input logic          ack_o,
  input logic          busy_o,
  input logic          pulse_o,
  input logic [3:0]    ctl_i,
  input logic          lat_valid_i,
  input logic [AW-1:0] lat_addr_i,
  input logic [15:0]   lat_data_i
);
  logic rd_mis;
  assign rd_mis = req_i && !we_i && !ctl_sel_i && !byte_i && addr_i[0];

  a_r4_frozen_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[2] |=> $stable({ctl_i[3], ctl_i[1:0]}));

  a_r3_go_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_i[2]) |-> $past(ctl_i[0] && lat_valid_i));

  a_r10_pulse_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);

  a_r7_pulse_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ctl_i[0]);

  a_r5_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_valid_i && ctl_i[0]) |=> (!ctl_i[0] || $stable({lat_addr_i, lat_data_i})));

  a_r11_mis_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mis && !ack_o) |=> (!rd_mis || ack_o));
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .ctl_sel_i  (ctl_sel_i),
  .byte_i     (byte_i),
  .addr_i     (addr_i),
  .ack_o      (ack_o),
  .busy_o     (busy_o),
  .pulse_o    (pulse_o),
  .ctl_i      (ctl_q),
  .lat_valid_i(lat_valid),
  .lat_addr_i (lat_addr),
  .lat_data_i (lat_data)
);

// File: tb/flash_pe_ctrl_tb.sv
module flash_pe_ctrl_tb;
  localparam int DEPTH = 32;
  localparam int BOOTB = 8;
  localparam int PCYC  = 16;
  localparam int AW    = 5;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, csel = 0, b8 = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic ack, busy, pulse;

  int checks = 0, errors = 0;

  flash_pe_ctrl #(.DEPTH(DEPTH), .BOOT_BYTES(BOOTB), .PULSE_CYC(PCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .ctl_sel_i(csel),
    .byte_i(b8), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .busy_o(busy), .pulse_o(pulse));

  always #5 clk = ~clk;

  // reference model
  logic [7:0]    m_mem [DEPTH];
  logic          m_arm, m_erase, m_go, m_boot, m_valid, m_lb8;
  logic [AW-1:0] m_laddr;
  logic [15:0]   m_ldata;

  function automatic logic m_ctl_write(input logic [3:0] d);
    logic nv, st;
    st = 1'b0;
    if (m_go) m_go = d[2];
    else begin
      nv = d[2] && m_arm && m_valid;
      st = nv && d[0];
      m_arm = d[0]; m_erase = d[1]; m_boot = d[3]; m_go = nv;
      if (!m_arm) begin m_valid = 0; m_ldata = 0; m_laddr = 0; m_lb8 = 0; end
    end
    return st;
  endfunction

  function automatic void m_arr_write(input logic bb, input logic [AW-1:0] a, input logic [15:0] d);
    if (m_arm && !m_valid && (bb || !a[0])) begin
      m_valid = 1; m_lb8 = bb; m_laddr = a; m_ldata = d;
    end
  endfunction

  function automatic void m_apply();
    if (m_erase) begin
      for (int i = 0; i < DEPTH; i++)
        if (!(m_boot && i >= DEPTH - BOOTB)) m_mem[i] = 8'hFF;
    end else begin
      m_mem[m_laddr] = m_mem[m_laddr] & m_ldata[7:0];
      if (!m_lb8) m_mem[m_laddr + 5'd1] = m_mem[m_laddr + 5'd1] & m_ldata[15:8];
    end
  endfunction

  function automatic logic [15:0] exp_read(input logic c, input logic bb, input logic [AW-1:0] a);
    if (c) return {12'h000, m_boot, m_go, m_erase, m_arm};
    if (m_go) return 16'h0000;
    if (m_arm && !m_erase) return m_ldata;
    if (bb) return {8'h00, m_mem[a]};
    return {m_mem[a + 5'd1], m_mem[a]};
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic bb, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; we = 1; csel = c; b8 = bb; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic c, input logic bb, input logic [AW-1:0] a,
                        output logic [15:0] d, output int cyc);
    @(negedge clk);
    req = 1; we = 0; csel = c; b8 = bb; addr = a;
    cyc = 1;
    #1;
    while (!ack && cyc < 10) begin @(negedge clk); #1; cyc++; end
    d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic rd_chk(input string r, input logic c, input logic bb, input logic [AW-1:0] a);
    logic [15:0] d; int cy;
    bus_rd(c, bb, a, d, cy);
    chk(r, d, exp_read(c, bb, a));
  endtask

  task automatic ctl_wr(input logic [3:0] d, output logic st);
    bus_wr(1, 0, '0, {12'h000, d});
    st = m_ctl_write(d);
  endtask

  task automatic arr_wr(input logic bb, input logic [AW-1:0] a, input logic [15:0] d);
    bus_wr(0, bb, a, d);
    m_arr_write(bb, a, d);
  endtask

  task automatic count_pulse(output int n);
    n = 0; #1;
    while (pulse && n < 1000) begin n++; @(negedge clk); #1; end
  endtask

  // arm (with erase/boot), capture, go, pulse, release
  task automatic run_op(input logic ers, input logic bt, input logic bb,
                        input logic [AW-1:0] a, input logic [15:0] d);
    logic st; int n;
    ctl_wr({bt, 1'b0, ers, 1'b1}, st);
    arr_wr(bb, a, d);
    ctl_wr({bt, 1'b1, ers, 1'b1}, st);
    if (st) begin
      count_pulse(n);
      chk("R10 pulse length", n, PCYC);
      m_apply();
      chk("R10 busy held after pulse", busy, 1);
    end
    ctl_wr(4'h0, st);
    chk("R10 busy cleared", busy, 0);
    ctl_wr(4'h0, st);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic st; logic [15:0] d; int cy, n;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    m_arm = 0; m_erase = 0; m_go = 0; m_boot = 0; m_valid = 0; m_lb8 = 0;
    m_laddr = 0; m_ldata = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 pulse", pulse, 0);
    rd_chk("R1 ctl", 1, 0, '0);
    bus_rd(0, 0, 5'd0, d, cy); chk("R1 array", d, 16'hFFFF);
    bus_rd(0, 1, 5'd31, d, cy); chk("R1 array top", d, 16'h00FF);

    // R2 plain write ignored
    arr_wr(0, 5'd2, 16'h1234);
    bus_rd(0, 0, 5'd2, d, cy); chk("R2 write ignored", d, 16'hFFFF);

    // R3 go gating
    ctl_wr(4'h4, st); rd_chk("R3 go without arm", 1, 0, '0);
    ctl_wr(4'h1, st);
    ctl_wr(4'h5, st);
    bus_rd(1, 0, '0, d, cy); chk("R3 go without capture", d, 16'h0001);

    // R5 / R6 capture and redirected reads
    arr_wr(1, 5'd5, 16'hA53C);
    bus_rd(0, 0, 5'd20, d, cy); chk("R6 latch redirect", d, 16'hA53C);
    arr_wr(0, 5'd6, 16'h1111);
    bus_rd(0, 1, 5'd6, d, cy); chk("R5 second write ignored", d, 16'hA53C);
    ctl_wr(4'h3, st);
    bus_rd(0, 1, 5'd5, d, cy); chk("R6 erase-set normal read", d, 16'h00FF);
    ctl_wr(4'h1, st);
    ctl_wr(4'h5, st);
    chk("R3 go set after capture", st, 1);
    #1 chk("R10 pulse starts", pulse, 1);
    ctl_wr(4'hE, st);   // tries arm=0 erase=1 boot=1, go stays
    bus_rd(1, 0, '0, d, cy); chk("R4 frozen bits", d, 16'h0005);
    bus_rd(0, 0, 5'd5, d, cy); chk("R6 read blocked", d, 16'h0000);
    count_pulse(n);
    m_apply();
    ctl_wr(4'h0, st); ctl_wr(4'h0, st);
    bus_rd(1, 0, '0, d, cy); chk("R4 go write then release", d, 16'h0000);
    bus_rd(0, 1, 5'd5, d, cy); chk("R8 byte AND", d, 16'h003C);

    // R8 misaligned word write not captured, then aligned word
    ctl_wr(4'h1, st);
    arr_wr(0, 5'd9, 16'h0000);
    ctl_wr(4'h5, st);
    bus_rd(1, 0, '0, d, cy); chk("R8 misaligned not captured", d, 16'h0001);
    ctl_wr(4'h0, st);
    run_op(0, 0, 0, 5'd8, 16'h0F3F);
    bus_rd(0, 0, 5'd8, d, cy); chk("R8 word AND", d, 16'h0F3F);
    run_op(0, 0, 0, 5'd8, 16'hF0F7);
    bus_rd(0, 0, 5'd8, d, cy); chk("R8 only clears bits", d, 16'h0037);

    // R7 go set while arm cleared in same write
    ctl_wr(4'h1, st); arr_wr(1, 5'd12, 16'h0000);
    ctl_wr(4'h4, st);
    #1 chk("R7 busy", busy, 1);
    repeat (PCYC + 2) @(negedge clk);
    #1 chk("R7 no pulse", pulse, 0);
    ctl_wr(4'h0, st);
    bus_rd(0, 1, 5'd12, d, cy); chk("R7 array unchanged", d, 16'h00FF);

    // R10 abort
    ctl_wr(4'h1, st); arr_wr(1, 5'd13, 16'h0000);
    ctl_wr(4'h5, st);
    repeat (5) @(negedge clk);
    ctl_wr(4'h1, st);
    #1 chk("R10 abort pulse", pulse, 0);
    repeat (PCYC) @(negedge clk);
    ctl_wr(4'h0, st);
    bus_rd(0, 1, 5'd13, d, cy); chk("R10 abort no change", d, 16'h00FF);

    // R9 erase with and without boot lock
    run_op(0, 0, 1, 5'd31, 16'h0000);
    run_op(0, 0, 1, 5'd0, 16'h0000);
    run_op(1, 1, 1, 5'd3, 16'h0000);
    bus_rd(0, 1, 5'd0, d, cy); chk("R9 erase low", d, 16'h00FF);
    bus_rd(0, 1, 5'd31, d, cy); chk("R9 boot protected", d, 16'h0000);
    run_op(1, 0, 1, 5'd3, 16'h0000);
    bus_rd(0, 1, 5'd31, d, cy); chk("R9 full erase", d, 16'h00FF);
    bus_rd(0, 0, 5'd8, d, cy); chk("R9 full erase word", d, 16'hFFFF);

    // R11 ack timing
    bus_rd(0, 0, 5'd4, d, cy); chk("R11 aligned cycles", cy, 1);
    bus_rd(0, 1, 5'd7, d, cy); chk("R11 byte cycles", cy, 1);
    run_op(0, 0, 0, 5'd10, 16'h5AA5);
    bus_rd(0, 0, 5'd9, d, cy); chk("R11 misaligned cycles", cy, 2);
    chk("R11 misaligned data", d, exp_read(0, 0, 5'd9));

    // random programs and reads against the model
    for (int it = 0; it < 30; it++) begin
      logic rb; logic [AW-1:0] ra; logic [15:0] rd;
      rb = 1'($urandom);
      ra = AW'($urandom);
      if (!rb) ra[0] = 1'b0;
      rd = 16'($urandom);
      run_op(($urandom % 8) == 0, 1'($urandom), rb, ra, rd);
      for (int k = 0; k < 3; k++) begin
        logic qb; logic [AW-1:0] qa;
        qb = 1'($urandom); qa = AW'($urandom);
        rd_chk("R8 random readback", 0, qb, qa);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule